// File: doc/BRIEF.md
# Latency-Hiding Streaming Accumulator

This block sums a run of N unsigned integers that arrive as a stream, one per clock, even though its adder needs several cycles to produce each sum. A single running total would have to wait for the previous addition to finish before it could take the next element. Instead, the block keeps a ring of independent partial sums. Each accepted element is added to the partial sum at the ring's read position, the read position moves on by one slot, and the adder result returns later to the slot it came from. When that slot is needed again, its sum has already come back. After the last element, and after every addition still in the adder has landed, a registered binary adder tree sums all slots. The block then shows the total and pulses a done flag.

A run begins with a one-cycle `start` while the block is idle, with the element count on `count`. Elements enter on a valid/ready handshake. An element moves only in a cycle where `in_valid` and `in_ready` are both high. The source may hold `in_valid` low for any number of cycles. The block lowers `in_ready` to apply back-pressure whenever it will not take an element: outside a run, and in a run once N elements have been taken. The result has no handshake. It is a plain output qualified by the one-cycle `done` strobe, and it keeps its value until the next run's reduction completes.

Top module: `psa_accum`

## Requirements
- R1: After reset, `done` is 0, `in_ready` is 0 and `result` is 0.
- R2: A `start` pulse seen while idle captures `count` as N and clears every partial sum. `in_ready` is then 1 until N elements have been accepted.
- R3: An element is consumed only on a cycle where `in_valid` and `in_ready` are both 1. Once the N-th element has been taken, `in_ready` is 0, and beats offered after that have no effect on `result`.
- R4: `result` equals the sum of the N accepted elements, each zero-extended, taken modulo 2^ACC_W. This holds for any N, including N greater than DEPTH, and for any pattern of gaps in `in_valid`.
- R5: ADD_LAT is smaller than DEPTH. The slot being read is never the slot the adder is writing back in the same cycle, and the adder pipeline is empty whenever the block is idle.
- R6: With N = 0, `result` is 0 and `done` rises exactly 1 + ceil(log2(DEPTH)) cycles after the clock edge that samples `start`.
- R7: `done` is high for exactly one cycle per run. `result` holds its value from that cycle until the next run's reduction completes, and `done` is never high while elements are still being taken.
- R8: A `start` pulse that arrives while a run or its reduction is in progress is ignored. The run in progress keeps its original N and its partial sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; taken only while idle |
| count | input | CNT_W | Number of elements N in the run |
| in_valid | input | 1 | Source offers an element |
| in_ready | output | 1 | Block will accept an element this cycle |
| in_data | input | DATA_W | Element value, unsigned |
| done | output | 1 | One-cycle strobe: result is ready |
| result | output | ACC_W | Total of the last completed run |

## Verification
The hardest case to reach from the ports is the one where a slot comes up for reuse while its previous sum is still close to leaving the adder. That case needs more than DEPTH elements with few gaps, so the ring wraps several times while ADD_LAT is only one less than DEPTH. The stimulus covers it with runs of several times DEPTH elements at high `in_valid` density. It also uses runs of exactly DEPTH-1, DEPTH and DEPTH+1 elements, and runs with sparse, random `in_valid` patterns. Further runs inject a mid-run `start` and offer extra beats after the N-th element, to show that neither disturbs the total.

// File: rtl/psa_pkg.sv
package psa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_RED  = 2'd2
  } psa_state_e;
endpackage

// File: rtl/psa_add_pipe.sv
// Integer adder followed by LAT register stages; each sum carries its slot tag.
module psa_add_pipe #(
  parameter int W     = 32,
  parameter int LAT   = 11,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_v,
  output logic [W-1:0]     out_sum,
  output logic [TAG_W-1:0] out_tag,
  output logic             busy
);
  logic [LAT-1:0]   v_q;
  logic [W-1:0]     s_q [LAT];
  logic [TAG_W-1:0] t_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int k = 0; k < LAT; k++) begin
        s_q[k] <= '0;
        t_q[k] <= '0;
      end
    end else begin
      v_q[0] <= in_v;
      s_q[0] <= a + b;
      t_q[0] <= in_tag;
      for (int k = 1; k < LAT; k++) begin
        v_q[k] <= v_q[k-1];
        s_q[k] <= s_q[k-1];
        t_q[k] <= t_q[k-1];
      end
    end
  end

  assign out_v   = v_q[LAT-1];
  assign out_sum = s_q[LAT-1];
  assign out_tag = t_q[LAT-1];
  assign busy    = |v_q;
endmodule

// File: rtl/psa_ring.sv
// Bank of D partial sums with a rotating read pointer and tagged write-back.
module psa_ring #(
  parameter int W     = 32,
  parameter int D     = 12,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rd_en,
  output logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  output logic [D*W-1:0]   slots_flat
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (clr)    ptr_q <= '0;
    else if (rd_en)  ptr_q <= (ptr_q == IDX_W'(D - 1)) ? '0 : ptr_q + 1'b1;
  end

  for (genvar g = 0; g < D; g++) begin : g_slot
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             q <= '0;
      else if (clr)                           q <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))  q <= wr_data;
    end
    assign slots_flat[g*W +: W] = q;
  end

  assign rd_idx  = ptr_q;
  assign rd_data = slots_flat[ptr_q*W +: W];

  AST_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |-> (wr_idx != ptr_q)); // R5
endmodule

// File: rtl/psa_reduce.sv
// Registered binary tree over D partial sums; heap indexed, leaves zero padded.
module psa_reduce #(
  parameter int W = 32,
  parameter int D = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [D*W-1:0] leaves,
  output logic           done,
  output logic [W-1:0]   result
);
  localparam int LVL    = $clog2(D);
  localparam int LEAVES = 1 << LVL;
  localparam int NODES  = 2 * LEAVES;

  logic [LEAVES*W-1:0] pad;
  logic [W-1:0]        node [1:NODES-1];
  logic [LVL+1:1]      ld_q;
  logic [LVL+1:0]      ld_all;

  assign pad    = (LEAVES*W)'(leaves);
  assign ld_all = {ld_q, go};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q <= '0;
      for (int i = 1; i < NODES; i++) node[i] <= '0;
    end else begin
      ld_q <= ld_all[LVL:0];
      for (int i = 1; i < NODES; i++) begin
        if (i >= LEAVES) begin
          if (ld_all[0]) node[i] <= pad[(i-LEAVES)*W +: W];
        end else if (ld_all[LVL - ($clog2(i+1) - 1)]) begin
          node[i] <= node[2*i] + node[2*i+1];
        end
      end
    end
  end

  assign done   = ld_q[LVL+1];
  assign result = node[1];

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
endmodule

// File: rtl/psa_accum.sv
module psa_accum
  import psa_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ACC_W   = 32,
  parameter int DEPTH   = 12,
  parameter int ADD_LAT = 11,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  count,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              done,
  output logic [ACC_W-1:0]  result
);
  localparam int IDX_W = $clog2(DEPTH);

  psa_state_e       state_q;
  logic [CNT_W-1:0] rem_q;
  logic             accept, clr, go, pipe_busy;
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [ACC_W-1:0] rd_data, wr_data;
  logic             wr_en;
  logic [DEPTH*ACC_W-1:0] slots;

  assign in_ready = (state_q == ST_RUN) && (rem_q != '0);
  assign accept   = in_valid && in_ready;
  assign clr      = (state_q == ST_IDLE) && start;
  assign go       = (state_q == ST_RUN) && (rem_q == '0) && !pipe_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_RUN;
          rem_q   <= count;
        end
        ST_RUN: begin
          if (accept) rem_q <= rem_q - 1'b1;
          if (go)     state_q <= ST_RED;
        end
        ST_RED:  if (done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  psa_ring #(.W(ACC_W), .D(DEPTH), .IDX_W(IDX_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .rd_en(accept), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .slots_flat(slots)
  );

  psa_add_pipe #(.W(ACC_W), .LAT(ADD_LAT), .TAG_W(IDX_W)) u_add (
    .clk(clk), .rst_n(rst_n), .in_v(accept),
    .a(rd_data), .b(ACC_W'(in_data)), .in_tag(rd_idx),
    .out_v(wr_en), .out_sum(wr_data), .out_tag(wr_idx), .busy(pipe_busy)
  );

  psa_reduce #(.W(ACC_W), .D(DEPTH)) u_red (
    .clk(clk), .rst_n(rst_n), .go(go), .leaves(slots),
    .done(done), .result(result)
  );

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !pipe_busy); // R5
  AST_QUIET_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> !done); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |=> $stable(result)); // R7
endmodule

// File: tb/tb_psa_accum.sv
module tb_psa_accum;
  localparam int DATA_W = 16, ACC_W = 32, DEPTH = 12, ADD_LAT = 11, CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, in_valid = 1'b0;
  logic [CNT_W-1:0]  count = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, done;
  logic [ACC_W-1:0] result;

  int checks = 0, failures = 0, cycles = 0;
  logic [DATA_W-1:0] mem [256];

  always #10 clk = ~clk;

  psa_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W), .DEPTH(DEPTH), .ADD_LAT(ADD_LAT),
              .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .count(count),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .done(done), .result(result));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [ACC_W-1:0] ref_sum(input int n);
    logic [ACC_W-1:0] s = '0;
    for (int k = 0; k < n; k++) s = s + ACC_W'(mem[k]);
    return s;
  endfunction

  // pat: 0 random values, 1 all ones; vpct: in_valid density in percent
  task automatic run(input int n, input int pat, input int vpct, input bit poke,
                     input int extra, input string req);
    int sent = 0, cyc = 0;
    bit hs;
    logic [ACC_W-1:0] exp, held;
    for (int k = 0; k < n; k++) mem[k] = (pat == 1) ? '1 : DATA_W'($urandom);
    exp = ref_sum(n);
    @(negedge clk); start = 1'b1; count = CNT_W'(n);
    @(negedge clk); start = 1'b0; count = '0;
    if (n > 0) chk(in_ready == 1'b1, "R2 ready after start", in_ready, 1);
    while (sent < n && cyc < 20000) begin
      in_valid = (($urandom % 100) < vpct);
      in_data  = mem[sent];
      if (poke && sent == n / 2) begin start = 1'b1; count = 16'd7; end
      hs = in_valid && in_ready;
      @(negedge clk);
      start = 1'b0;
      if (hs) sent++;
      cyc++;
    end
    in_valid = 1'b0;
    if (n > 0) chk(in_ready == 1'b0, "R3 ready low after N", in_ready, 0);
    for (int e = 0; e < extra; e++) begin
      in_valid = 1'b1; in_data = '1;
      @(negedge clk);
    end
    in_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    chk(done == 1'b1, {req, " done seen"}, done, 1);
    chk(result == exp, {req, " total"}, result, exp);
    if (n == 0 && extra == 0)
      chk(cyc == 1 + $clog2(DEPTH), "R6 empty-run latency", cyc, 1 + $clog2(DEPTH));
    held = result;
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(result == held, "R7 result held", result, held);
  endtask

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done at reset", done, 0);
    chk(in_ready == 1'b0, "R1 ready at reset", in_ready, 0);
    chk(result == '0, "R1 result at reset", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: beats offered while idle are refused
    in_valid = 1'b1; @(negedge clk);
    chk(in_ready == 1'b0, "R3 idle refuses beats", in_ready, 0);
    in_valid = 1'b0;

    run(5, 0, 100, 1'b0, 0, "R4 short");
    run(0, 0, 100, 1'b0, 0, "R6 empty");
    run(1, 0, 100, 1'b0, 0, "R4 single");
    run(DEPTH - 1, 0, 100, 1'b0, 0, "R4 D-1");
    run(DEPTH, 0, 100, 1'b0, 0, "R4 D");
    run(DEPTH + 1, 0, 100, 1'b0, 0, "R4 D+1");
    run(4 * DEPTH + 5, 0, 100, 1'b0, 0, "R5 dense wrap");
    run(200, 1, 100, 1'b0, 0, "R4 wrap all ones");
    run(30, 0, 100, 1'b0, 6, "R3 extra beats ignored");
    run(40, 0, 70, 1'b1, 0, "R8 start mid-run ignored");
    run(25, 0, 20, 1'b0, 0, "R4 sparse valid");
    for (int r = 0; r < 20; r++)
      run(int'($urandom % 60), 0, 30 + int'($urandom % 71), 1'b0,
          int'($urandom % 3), "R4 random");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule